// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for every beat of a four-beat burst in front of a synchronous memory array. When the advance/load control is low on a clock-enabled edge with the chip selected, the external address is captured and a new burst starts. Each later enabled edge with advance/load high steps a two-bit beat index. The low two address bits follow either a wrapping linear count or an XOR pattern, picked by a static order-select input. The upper address bits never change during a burst.

A load while the chip is deselected ends the current burst. Dropping the clock enable freezes every register, as if the edge had not happened. All controls are sampled on the rising edge. The address output comes from registers and is valid in the cycle after the edge that loaded or stepped it.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `burst_active` is 0 and `burst_addr` is 0.
- R2: An enabled edge with `adv_n_ld` low and `chip_sel` high makes `burst_active` 1 and `burst_addr` equal to the `ext_addr` sampled at that edge, in either ordering mode.
- R3: With `order_ilv` low (linear), after k advancing edges since the load, the low two bits of `burst_addr` equal (start + k) mod 4. A start of 2 gives 2,3,0,1.
- R4: With `order_ilv` high (interleaved), after k advancing edges, the low two bits equal start XOR (k mod 4). A start of 1 gives 1,0,3,2, and a start of 2 gives 2,3,0,1.
- R5: Bits above bit 1 of `burst_addr` keep their loaded value through any number of advances. After four beats the sequence returns to its start and never carries into the upper bits.
- R6: On an advancing edge (`adv_n_ld` high) the value on `ext_addr` has no effect on `burst_addr`.
- R7: An enabled edge with `adv_n_ld` low and `chip_sel` low clears `burst_active` and leaves `burst_addr` unchanged.
- R8: An edge with `clk_en` low changes neither `burst_addr` nor `burst_active`, whatever the other inputs are.
- R9: An enabled advancing edge while `burst_active` is 0 changes neither output.
- R10: `chip_sel` is only looked at on load edges. An advancing edge with `chip_sel` low still steps an active burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | High lets an edge take effect; low freezes all state |
| chip_sel | input | 1 | Combined chip-select result, high when selected |
| adv_n_ld | input | 1 | High steps the burst, low loads (or ends, when deselected) |
| order_ilv | input | 1 | Static order select: 1 interleaved, 0 linear |
| ext_addr | input | ADDR_W (17) | External start address |
| burst_addr | output | ADDR_W (17) | Address of the current beat |
| burst_active | output | 1 | High while a burst is in progress |

## Verification
A wrong beat index or captured start shows on the low two bits of `burst_addr` in the cycle after the first faulty edge. Each advance is checked in that cycle, so a bad step is caught within one beat. A carry or a stray capture corrupts the upper bits, and every observed beat compares them as well. A wrong burst flag after a deselect or a frozen edge shows at once on `burst_active`. An idle advance that changes the address also shows one cycle later.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    ACT_NONE     = 2'd0,
    ACT_LOAD     = 2'd1,
    ACT_STEP     = 2'd2,
    ACT_TERMINATE = 2'd3
  } action_e;
endpackage

// File: rtl/burst_order_unit.sv
module burst_order_unit #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_low,
  input  logic [BEAT_W-1:0] beat_idx,
  input  logic              ilv_sel,
  output logic [BEAT_W-1:0] seq_low
);
  import burst_seq_pkg::*;

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  // Wrapping add: the width of the sum drops the carry out of the field.
  always_comb lin_low = start_low + beat_idx;

  genvar b;
  generate
    for (b = 0; b < BEAT_W; b++) begin : g_xor
      assign ilv_low[b] = start_low[b] ^ beat_idx[b];
    end
  endgenerate

  always_comb begin
    if (order_e'(ilv_sel) == ORD_INTERLEAVED) seq_low = ilv_low;
    else                                      seq_low = lin_low;
  end
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              chip_sel,
  input  logic              adv_n_ld,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] base_q,
  output logic [BEAT_W-1:0] beat_q,
  output logic              active_q
);
  import burst_seq_pkg::*;

  action_e act;

  always_comb begin
    act = ACT_NONE;
    if (clk_en) begin
      if (!adv_n_ld) act = chip_sel ? ACT_LOAD : ACT_TERMINATE;
      else if (active_q) act = ACT_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_LOAD: begin
          base_q   <= ext_addr;
          beat_q   <= '0;
          active_q <= 1'b1;
        end
        ACT_STEP:      beat_q   <= beat_q + 1'b1;
        ACT_TERMINATE: active_q <= 1'b0;
        default: ;
      endcase
    end
  end

  // R6: an advance leaves the captured start untouched
  a_r6_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_n_ld) |=> $stable(base_q));

  // R9: idle advance does nothing
  a_r9_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_n_ld && !active_q) |=> ($stable(beat_q) && !active_q));

  // R10: stepping ignores chip_sel
  a_r10_step_any_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_n_ld && active_q) |=> (active_q && beat_q == $past(beat_q) + 1'b1));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              chip_sel,
  input  logic              adv_n_ld,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] burst_addr,
  output logic              burst_active
);
  localparam int BEAT_W = 2;
  localparam int HI_W   = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] seq_low;

  burst_seq_ctrl #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .chip_sel (chip_sel),
    .adv_n_ld (adv_n_ld),
    .ext_addr (ext_addr),
    .base_q   (base_q),
    .beat_q   (beat_q),
    .active_q (burst_active)
  );

  burst_order_unit #(.BEAT_W(BEAT_W)) order_i (
    .start_low (base_q[BEAT_W-1:0]),
    .beat_idx  (beat_q),
    .ilv_sel   (order_ilv),
    .seq_low   (seq_low)
  );

  assign burst_addr = {base_q[ADDR_W-1:BEAT_W], seq_low};

  // R2: a selected load presents the external address next cycle
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv_n_ld && chip_sel) |=> (burst_active && burst_addr == $past(ext_addr)));

  // R5: upper bits hold while stepping
  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_n_ld) |=> $stable(burst_addr[ADDR_W-1:BEAT_W]));

  // R7: deselected load ends the burst
  a_r7_terminate: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv_n_ld && !chip_sel) |=> (!burst_active && $stable(burst_addr)));

  // R8: frozen edge
  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && $stable(order_ilv)) |=> ($stable(burst_addr) && $stable(burst_active)));

  initial begin
    a_r1_width: assert (HI_W > 0);
  end
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b0;
  logic chip_sel = 1'b0;
  logic adv_n_ld = 1'b1;
  logic order_ilv = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] burst_addr;
  logic burst_active;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .chip_sel(chip_sel),
    .adv_n_ld(adv_n_ld), .order_ilv(order_ilv), .ext_addr(ext_addr),
    .burst_addr(burst_addr), .burst_active(burst_active)
  );

  task automatic check(string req, logic [AW-1:0] act_a, logic [AW-1:0] exp_a,
                       logic act_v, logic exp_v);
    total++;
    if (act_a !== exp_a || act_v !== exp_v) begin
      bad++;
      $display("FAIL %s: addr=%h active=%b expected addr=%h active=%b",
               req, act_a, act_v, exp_a, exp_v);
    end
  endtask

  // one edge with the given controls; results sampled 1 ns after it
  task automatic edge_do(logic en, logic sel, logic adv, logic [AW-1:0] a);
    @(negedge clk);
    clk_en = en; chip_sel = sel; adv_n_ld = adv; ext_addr = a;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] s, int k, logic ilv);
    logic [1:0] lo;
    lo = ilv ? (s[1:0] ^ 2'(k)) : 2'(s[1:0] + 2'(k));
    return {s[AW-1:2], lo};
  endfunction

  task automatic t_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 in reset", burst_addr, '0, burst_active, 1'b0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1 after release", burst_addr, '0, burst_active, 1'b0);
  endtask

  task automatic t_burst(logic ilv, logic [AW-1:0] s, string req);
    order_ilv = ilv;
    edge_do(1, 1, 0, s);
    check("R2 load", burst_addr, s, burst_active, 1'b1);
    for (int k = 1; k <= 7; k++) begin
      // ext_addr noise while stepping also covers R6
      edge_do(1, 1, 1, ~s ^ AW'(k * 37));
      check(k >= 4 ? "R5 wrap" : req, burst_addr, expect_addr(s, k, ilv), burst_active, 1'b1);
    end
  endtask

  task automatic t_ignore_ext();
    order_ilv = 0;
    edge_do(1, 1, 0, 17'h00F30);
    edge_do(1, 1, 1, 17'h1FFFF);
    check("R6 ext ignored", burst_addr, 17'h00F31, burst_active, 1'b1);
  endtask

  task automatic t_freeze();
    order_ilv = 0;
    edge_do(1, 1, 0, 17'h05551);
    edge_do(1, 1, 1, '0);
    edge_do(0, 1, 0, 17'h1AAAA);
    check("R8 no load", burst_addr, 17'h05552, burst_active, 1'b1);
    edge_do(0, 1, 1, '0);
    check("R8 no step", burst_addr, 17'h05552, burst_active, 1'b1);
    edge_do(0, 0, 0, '0);
    check("R8 no terminate", burst_addr, 17'h05552, burst_active, 1'b1);
    edge_do(1, 1, 1, '0);
    check("R8 resume", burst_addr, 17'h05553, burst_active, 1'b1);
  endtask

  task automatic t_sel_step();
    order_ilv = 1;
    edge_do(1, 1, 0, 17'h12340);
    edge_do(1, 0, 1, '0);
    check("R10 step while deselected", burst_addr, 17'h12341, burst_active, 1'b1);
  endtask

  task automatic t_terminate();
    order_ilv = 0;
    edge_do(1, 1, 0, 17'h0BEE2);
    edge_do(1, 1, 1, '0);
    edge_do(1, 0, 0, 17'h00001);
    check("R7 terminate", burst_addr, 17'h0BEE3, burst_active, 1'b0);
    edge_do(1, 1, 1, 17'h1FFFF);
    check("R9 idle advance", burst_addr, 17'h0BEE3, burst_active, 1'b0);
    edge_do(1, 0, 1, '0);
    check("R9 idle advance deselected", burst_addr, 17'h0BEE3, burst_active, 1'b0);
    edge_do(1, 1, 0, 17'h00007);
    check("R2 reload after end", burst_addr, 17'h00007, burst_active, 1'b1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: addr=%h active=%b expected run to finish", burst_addr, burst_active);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_burst(0, 17'h0AB5E, "R3 linear");
    t_burst(0, 17'h1FFFF, "R3 linear");
    t_burst(1, 17'h04561, "R4 interleaved");
    t_burst(1, 17'h0C3A2, "R4 interleaved");
    t_ignore_ext();
    t_freeze();
    t_sel_step();
    t_terminate();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule